// File: doc/BRIEF.md
# 1-Wire ROM Search Sequencer

This block finds the 64-bit identity code of one device on a 1-Wire bus each time it is started. It uses the bus's binary-tree search. It does not drive the wire itself. It asks a separate bit-slot engine for one time slot at a time, and each slot is either a write of one bit or a read of one bit. A single request/done handshake carries every slot. The bus reset pulse must already have been issued before the sequencer is started.

A pass first writes an eight-bit search command, least significant bit first. For each code position, from bit 0 upward, the sequencer then reads the wired-AND of every device's bit and the wired-AND of every device's complement bit. It picks a direction bit and writes that bit back, so devices that disagree drop out of the pass. The position of the newest collision that was not resolved is kept between passes. Repeated starts therefore walk through every device on the bus. When the last device has been found, the next start begins again from scratch.

After each pass the block reports four things: the code found, whether more devices remain, whether the code passes the bus's reflected CRC-8, and whether the pass was aborted because no device answered.

Top module: `ows_search_top`

## Requirements
- R1: On an accepted start, the first eight slots are write slots carrying the command byte least significant bit first. The byte is 0xF0 when `alarm_only` is 0 and 0xEC when it is 1.
- R2: After the command, each code position p = 0..63 in ascending order uses three slots: a read of the true bit, then a read of the complement bit, then a write of the chosen direction bit. Bit p of `code` equals the bit that was written.
- R3: A read pair (true, complement) of (1,0) selects 1, and a pair of (0,1) selects 0.
- R4: A pair of (0,0) is a collision. At the stored discrepancy position the sequencer selects 1. Above that position it selects 0 and records the position. Below that position it repeats the previous pass's code bit, and records the position when that bit is 0. The highest recorded position becomes the new stored position.
- R5: A pair of (1,1) aborts the pass with no further slots. `done` pulses with `error`=1, `code`=0, `more`=0 and `crc_ok`=0. The stored position returns to "none" (value 64).
- R6: When no discrepancy is stored, or when `restart` is 1 at start, the search starts from scratch: the stored position is treated as 64 and `code` is cleared before the pass.
- R7: At the end of a completed pass, `more` is 1 exactly when a position was recorded during that pass.
- R8: `crc_ok` is 1 exactly when the reflected CRC-8 (polynomial 0x8C, initial value 0) over all 64 code bits, taken least significant bit first, leaves a zero remainder.
- R9: `start` is ignored while `busy` is 1. `done` is a one-cycle pulse. `code`, `more`, `crc_ok` and `error` hold their values until the next accepted start.
- R10: After reset the block is idle with every output at 0. `slot_req` is a one-cycle pulse, it is never raised while a slot is outstanding, and it is never raised while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one search pass |
| alarm_only | input | 1 | Search only devices flagging an alarm |
| restart | input | 1 | Forget the stored discrepancy and search from scratch |
| slot_req | output | 1 | One-cycle request for a bus slot |
| slot_write | output | 1 | 1: write slot, 0: read slot |
| slot_wbit | output | 1 | Bit to write in a write slot |
| slot_done | input | 1 | One-cycle pulse: requested slot finished |
| slot_rbit | input | 1 | Bit sampled in a read slot, valid with slot_done |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| code | output | 64 | Device code found |
| more | output | 1 | More devices remain to be enumerated |
| crc_ok | output | 1 | Found code has a zero CRC-8 remainder |
| error | output | 1 | Pass aborted: no device responded |

## Verification
The bench builds the block with its default 64-bit code and the standard 0xF0/0xEC command bytes. With these values, the device sets the bench uses produce collisions at bit 0, at bit 63 and at adjacent low positions, so all three branches of the collision rule are exercised. The bench models a responder with a two-cycle slot latency that does the wired-AND of up to four devices. This makes the bus's real deselection behaviour decide the enumeration order. The order the bench expects comes independently from sorting the devices by their bit-reversed codes.

// File: rtl/ows_pkg.sv
package ows_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_TRUE,
    ST_COMP,
    ST_DIR
  } ows_state_e;
endpackage

// File: rtl/ows_decide.sv
module ows_decide #(
  parameter int POS_W = 7
) (
  input  logic             t_bit,
  input  logic             c_bit,
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] mark,
  input  logic             prev_bit,
  output logic             dir,
  output logic             nodev,
  output logic             record
);
  always_comb begin
    dir    = 1'b0;
    nodev  = 1'b0;
    record = 1'b0;
    unique case ({t_bit, c_bit})
      2'b10: dir = 1'b1;
      2'b01: dir = 1'b0;
      2'b11: nodev = 1'b1;
      default: begin
        if (pos == mark) begin
          dir = 1'b1;
        end else if (pos > mark) begin
          dir    = 1'b0;
          record = 1'b1;
        end else begin
          dir    = prev_bit;
          record = ~prev_bit;
        end
      end
    endcase
  end
endmodule

// File: rtl/ows_crc8.sv
module ows_crc8 #(
  parameter logic [7:0] POLY = 8'h8C
) (
  input  logic       clk,
  input  logic       rst_i,
  input  logic       clr,
  input  logic       en,
  input  logic       din,
  output logic [7:0] rem
);
  logic [7:0] rem_q, rem_d;
  logic       fb;

  always_comb begin
    fb    = rem_q[0] ^ din;
    rem_d = rem_q;
    if (clr) begin
      rem_d = '0;
    end else if (en) begin
      rem_d = {1'b0, rem_q[7:1]} ^ (fb ? POLY : 8'h00);
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  assign rem = rem_q;
endmodule

// File: rtl/ows_search_top.sv
module ows_search_top
  import ows_pkg::*;
#(
  parameter int                  CODE_BITS  = 64,
  parameter int                  CMD_BITS   = 8,
  parameter logic [CMD_BITS-1:0] SEARCH_CMD = 8'hF0,
  parameter logic [CMD_BITS-1:0] ALARM_CMD  = 8'hEC,
  parameter logic [7:0]          CRC_POLY   = 8'h8C
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 alarm_only,
  input  logic                 restart,
  output logic                 slot_req,
  output logic                 slot_write,
  output logic                 slot_wbit,
  input  logic                 slot_done,
  input  logic                 slot_rbit,
  output logic                 busy,
  output logic                 done,
  output logic [CODE_BITS-1:0] code,
  output logic                 more,
  output logic                 crc_ok,
  output logic                 error
);
  localparam int IDX_W = $clog2(CODE_BITS);
  localparam int POS_W = $clog2(CODE_BITS + 1);
  localparam logic [POS_W-1:0] MARK_NONE = POS_W'(CODE_BITS);
  localparam logic [IDX_W-1:0] LAST_CMD  = IDX_W'(CMD_BITS - 1);
  localparam logic [IDX_W-1:0] LAST_POS  = IDX_W'(CODE_BITS - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  ows_state_e           state_q, state_d;
  logic                 wait_q, wait_d;
  logic [IDX_W-1:0]     pos_q, pos_d;
  logic [CMD_BITS-1:0]  cmd_q, cmd_d;
  logic                 t_q, t_d;
  logic                 dir_q, dir_d;
  logic [CODE_BITS-1:0] code_q, code_d;
  logic [POS_W-1:0]     mark_q, mark_d, newd_q, newd_d, mark_eff;
  logic                 more_q, more_d, crcok_q, crcok_d, err_q, err_d;
  logic                 done_q, done_d;
  logic                 crc_clr, crc_en;
  logic [7:0]           crc_rem;
  logic                 dec_dir, dec_nodev, dec_rec;

  ows_decide #(.POS_W(POS_W)) u_decide (
    .t_bit    (t_q),
    .c_bit    (slot_rbit),
    .pos      (POS_W'(pos_q)),
    .mark     (mark_q),
    .prev_bit (code_q[pos_q]),
    .dir      (dec_dir),
    .nodev    (dec_nodev),
    .record   (dec_rec)
  );

  ows_crc8 #(.POLY(CRC_POLY)) u_crc (
    .clk   (clk),
    .rst_i (rst_i),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (dec_dir),
    .rem   (crc_rem)
  );

  assign mark_eff = restart ? MARK_NONE : mark_q;

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    pos_d   = pos_q;
    cmd_d   = cmd_q;
    t_d     = t_q;
    dir_d   = dir_q;
    code_d  = code_q;
    mark_d  = mark_q;
    newd_d  = newd_q;
    more_d  = more_q;
    crcok_d = crcok_q;
    err_d   = err_q;
    done_d  = 1'b0;
    crc_clr = 1'b0;
    crc_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_CMD;
          wait_d  = 1'b0;
          pos_d   = '0;
          cmd_d   = alarm_only ? ALARM_CMD : SEARCH_CMD;
          mark_d  = mark_eff;
          if (mark_eff == MARK_NONE) code_d = '0;
          newd_d  = MARK_NONE;
          more_d  = 1'b0;
          crcok_d = 1'b0;
          err_d   = 1'b0;
          crc_clr = 1'b1;
        end
      end
      ST_CMD: begin
        if (!wait_q) begin
          wait_d = 1'b1;
        end else if (slot_done) begin
          wait_d = 1'b0;
          cmd_d  = cmd_q >> 1;
          if (pos_q == LAST_CMD) begin
            pos_d   = '0;
            state_d = ST_TRUE;
          end else begin
            pos_d = pos_q + 1'b1;
          end
        end
      end
      ST_TRUE: begin
        if (!wait_q) begin
          wait_d = 1'b1;
        end else if (slot_done) begin
          wait_d  = 1'b0;
          t_d     = slot_rbit;
          state_d = ST_COMP;
        end
      end
      ST_COMP: begin
        if (!wait_q) begin
          wait_d = 1'b1;
        end else if (slot_done) begin
          wait_d = 1'b0;
          if (dec_nodev) begin
            state_d = ST_IDLE;
            code_d  = '0;
            mark_d  = MARK_NONE;
            more_d  = 1'b0;
            crcok_d = 1'b0;
            err_d   = 1'b1;
            done_d  = 1'b1;
          end else begin
            dir_d         = dec_dir;
            code_d[pos_q] = dec_dir;
            crc_en        = 1'b1;
            if (dec_rec) newd_d = POS_W'(pos_q);
            state_d = ST_DIR;
          end
        end
      end
      ST_DIR: begin
        if (!wait_q) begin
          wait_d = 1'b1;
        end else if (slot_done) begin
          wait_d = 1'b0;
          if (pos_q == LAST_POS) begin
            state_d = ST_IDLE;
            mark_d  = newd_q;
            more_d  = (newd_q != MARK_NONE);
            crcok_d = (crc_rem == 8'h00);
            done_d  = 1'b1;
          end else begin
            pos_d   = pos_q + 1'b1;
            state_d = ST_TRUE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      wait_q  <= 1'b0;
      pos_q   <= '0;
      cmd_q   <= '0;
      t_q     <= 1'b0;
      dir_q   <= 1'b0;
      code_q  <= '0;
      mark_q  <= MARK_NONE;
      newd_q  <= MARK_NONE;
      more_q  <= 1'b0;
      crcok_q <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      pos_q   <= pos_d;
      cmd_q   <= cmd_d;
      t_q     <= t_d;
      dir_q   <= dir_d;
      code_q  <= code_d;
      mark_q  <= mark_d;
      newd_q  <= newd_d;
      more_q  <= more_d;
      crcok_q <= crcok_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign slot_req   = busy && !wait_q;
  assign slot_write = (state_q == ST_CMD) || (state_q == ST_DIR);
  assign slot_wbit  = (state_q == ST_CMD) ? cmd_q[0] : dir_q;
  assign done       = done_q;
  assign code       = code_q;
  assign more       = more_q;
  assign crc_ok     = crcok_q;
  assign error      = err_q;
endmodule

// File: rtl/ows_search_chk.sv
module ows_search_chk #(
  parameter int CODE_BITS = 64,
  parameter int CMD_BITS  = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 error,
  input logic                 more,
  input logic                 crc_ok,
  input logic [CODE_BITS-1:0] code,
  input logic                 slot_req,
  input logic                 slot_write,
  input logic                 slot_done
);
  logic        pend_q;
  logic [15:0] scnt_q;
  logic [1:0]  ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      scnt_q <= '0;
      ph_q   <= '0;
    end else begin
      if (slot_req)       pend_q <= 1'b1;
      else if (slot_done) pend_q <= 1'b0;
      if (start && !busy) begin
        scnt_q <= '0;
        ph_q   <= '0;
      end else if (slot_req) begin
        if (scnt_q != 16'hFFFF) scnt_q <= scnt_q + 16'd1;
        if (scnt_q >= 16'(CMD_BITS)) ph_q <= (ph_q == 2'd2) ? 2'd0 : ph_q + 2'd1;
      end
    end
  end

  a_r10_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req |-> !pend_q);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !slot_req);
  a_r1_cmd_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && scnt_q < 16'(CMD_BITS)) |-> slot_write);
  a_r2_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && scnt_q >= 16'(CMD_BITS)) |-> (slot_write == (ph_q == 2'd2)));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_abort_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done && error) |-> (code == '0 && !more && !crc_ok));
  a_r7_more_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done && more) |-> !error);
endmodule

bind ows_search_top ows_search_chk #(.CODE_BITS(CODE_BITS), .CMD_BITS(CMD_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .error      (error),
  .more       (more),
  .crc_ok     (crc_ok),
  .code       (code),
  .slot_req   (slot_req),
  .slot_write (slot_write),
  .slot_done  (slot_done)
);

// File: tb/sim_ows_search_top.sv
`timescale 1ns/1ps
module sim_ows_search_top;
  localparam int LAT = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, alarm_only, restart;
  logic slot_req, slot_write, slot_wbit, slot_done, slot_rbit;
  logic busy, done, more, crc_ok, error;
  logic [63:0] code;

  ows_search_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .alarm_only(alarm_only), .restart(restart),
    .slot_req(slot_req), .slot_write(slot_write), .slot_wbit(slot_wbit),
    .slot_done(slot_done), .slot_rbit(slot_rbit), .busy(busy), .done(done),
    .code(code), .more(more), .crc_ok(crc_ok), .error(error)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_n(logic [63:0] v, int nbytes);
    logic [7:0] c = 8'h00;
    for (int b = 0; b < nbytes; b++) begin
      c ^= v[8*b +: 8];
      for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ 8'h8C) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [63:0] mk(logic [55:0] body);
    return {crc_n({8'h00, body}, 7), body};
  endfunction

  function automatic logic [63:0] rev64(logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = v[63-i];
    return r;
  endfunction

  // device model on the bus
  logic [63:0] dcode [4];
  bit dpres [4], dalarm [4], dact [4];
  int slot_ix = 0, lat = 0, proto_err = 0;
  logic [7:0] cmd_rx;
  bit pw, pb;

  task automatic do_slot();
    bit rb;
    int j, p, ph;
    rb = 1'b1;
    if (slot_ix < 8) begin
      if (!pw) proto_err++;
      cmd_rx[slot_ix] = pb;
      if (slot_ix == 7)
        for (int k = 0; k < 4; k++)
          dact[k] = dpres[k] && (cmd_rx == 8'hF0 || (cmd_rx == 8'hEC && dalarm[k]));
    end else begin
      j = slot_ix - 8; p = j / 3; ph = j % 3;
      if (p >= 64) proto_err++;
      else if (ph == 0) begin
        if (pw) proto_err++;
        for (int k = 0; k < 4; k++) if (dact[k] && !dcode[k][p]) rb = 1'b0;
      end else if (ph == 1) begin
        if (pw) proto_err++;
        for (int k = 0; k < 4; k++) if (dact[k] && dcode[k][p]) rb = 1'b0;
      end else begin
        if (!pw) proto_err++;
        for (int k = 0; k < 4; k++) if (dact[k] && dcode[k][p] != pb) dact[k] = 0;
      end
    end
    slot_ix++;
    slot_rbit = rb;
    slot_done = 1'b1;
  endtask

  always @(negedge clk) begin
    if (slot_done) slot_done = 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) do_slot();
    end
    if (rst_n && slot_req) begin
      if (lat != 0) proto_err++;
      lat = LAT; pw = slot_write; pb = slot_wbit;
    end
  end

  // scoreboard
  typedef struct {logic [63:0] code; bit more; bit crc; bit err; string tag;} exp_t;
  exp_t sbq[$];
  logic [63:0] last_code;

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sbq.size() == 0) chk(0, "R9 unexpected done", 64'd1, 64'd0);
      else begin
        exp_t e;
        e = sbq.pop_front();
        chk(code == e.code, e.tag, code, e.code);
        chk(more == e.more, "R7 more flag", 64'(more), 64'(e.more));
        chk(crc_ok == e.crc, "R8 crc flag", 64'(crc_ok), 64'(e.crc));
        chk(error == e.err, "R5 error flag", 64'(error), 64'(e.err));
      end
    end
  end

  task automatic search(bit alm, bit rs, logic [63:0] ecode, bit emore, bit eerr,
                        string tag, bit poke);
    exp_t e;
    while (busy) @(negedge clk);
    slot_ix = 0;
    for (int k = 0; k < 4; k++) dact[k] = 0;
    e.code = ecode; e.more = emore; e.err = eerr; e.tag = tag;
    e.crc = eerr ? 1'b0 : (crc_n(ecode, 8) == 8'h00);
    sbq.push_back(e);
    last_code = ecode;
    @(negedge clk); start = 1; alarm_only = alm; restart = rs;
    @(negedge clk); start = 0; alarm_only = 0; restart = 0;
    if (poke) begin
      repeat (100) @(negedge clk);
      start = 1; alarm_only = 1; restart = 1;
      @(negedge clk); start = 0; alarm_only = 0; restart = 0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  logic [63:0] ord [4];
  int nord;

  task automatic build_ord(bit alm);
    logic [63:0] t;
    nord = 0;
    for (int k = 0; k < 4; k++)
      if (dpres[k] && (!alm || dalarm[k])) begin ord[nord] = dcode[k]; nord++; end
    for (int a = 0; a < nord; a++)
      for (int b = a + 1; b < nord; b++)
        if (rev64(ord[b]) < rev64(ord[a])) begin t = ord[a]; ord[a] = ord[b]; ord[b] = t; end
  endtask

  task automatic enumerate(bit alm, string tag);
    build_ord(alm);
    for (int i = 0; i < nord; i++) search(alm, i == 0, ord[i], i < nord - 1, 0, tag, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; alarm_only = 0; restart = 0; slot_done = 0; slot_rbit = 0;
    dcode[0] = mk(56'h000000_0000_0001); dcode[1] = mk(56'h000000_0000_0003);
    dcode[2] = mk(56'h000000_0000_0005); dcode[3] = mk(56'h000000_0000_0007);
    for (int k = 0; k < 4; k++) begin dpres[k] = 1; dalarm[k] = (k % 2) == 1; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(!busy, "R10 reset busy", 64'(busy), 0);
    chk(!slot_req, "R10 reset slot_req", 64'(slot_req), 0);
    chk(!done && !error && !more && !crc_ok, "R10 reset flags",
        {60'd0, done, error, more, crc_ok}, 0);
    chk(code == 0, "R10 reset code", code, 0);

    // R3 R4: four devices with collisions at adjacent low bits, full walk
    build_ord(0);
    for (int i = 0; i < 4; i++) search(0, 0, ord[i], i < 3, 0, "R4 enumerated code", 0);
    // R6: marker back to none after last device, next pass starts over
    search(0, 0, ord[0], 1, 0, "R6 wrap to first code", 0);
    search(0, 0, ord[1], 1, 0, "R4 second code", 0);
    search(0, 1, ord[0], 1, 0, "R6 restart to first code", 0);

    // R1: alarm-only command selects flagged devices
    enumerate(1, "R1 alarm search code");

    // R5: no device answers, then marker must be back to none
    for (int k = 0; k < 4; k++) dpres[k] = 0;
    search(0, 0, 64'd0, 0, 1, "R5 abort code cleared", 0);
    for (int k = 0; k < 4; k++) dpres[k] = 1;
    build_ord(0);
    search(0, 0, ord[0], 1, 0, "R5 next pass from scratch", 0);

    // R3 R8: single device with a bad check byte
    for (int k = 1; k < 4; k++) dpres[k] = 0;
    dcode[0] = 64'h0123_4567_89AB_CDEF;
    search(0, 1, dcode[0], 0, 0, "R3 single device code", 0);

    // R4: collisions at bit 0 and bit 63
    dcode[0] = mk(56'h12_3456_789A_BCDE);
    dcode[1] = dcode[0] ^ 64'd1;
    dcode[2] = dcode[0] ^ (64'd1 << 63);
    dpres[1] = 1; dpres[2] = 1;
    enumerate(0, "R4 boundary code");

    // R9: start during a pass is ignored, results held afterwards
    search(0, 1, ord[0], 1, 0, "R9 code with start poke", 1);
    repeat (50) @(negedge clk);
    chk(sbq.size() == 0, "R9 no extra pass", 64'(sbq.size()), 0);
    chk(!busy, "R9 idle after poke", 64'(busy), 0);
    chk(code == last_code, "R9 code held", code, last_code);

    chk(proto_err == 0, "R2 slot sequence", 64'(proto_err), 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule